// File: doc/BRIEF.md
# USB Device Global NAK Controller

This block holds the device-wide NAK override for each transfer direction of a full-speed USB device controller and picks the handshake for every transaction. Software drives it through a small two-word register window. The control word carries one-shot set and clear requests for the OUT and IN overrides, an initialization-complete bit and the two override status bits. The flag word holds one "override effective" flag per direction. Software clears a flag by writing one to its bit.

For each transaction the controller's token logic presents the direction, the FIFO readiness and the endpoint NAK and STALL bits. The block answers at once with a 2-bit handshake code. For OUT transactions it also gives a strobe that says whether the packet is to be stored. While an override is active, that direction is answered with NAK whatever the endpoint and the FIFO say. The effective flag confirms the override only once no transaction of that direction is still running. Software can use the flag to know that no transaction of that direction gets a non-NAK answer from then on.

Top module: `usb_gnak_ctrl`

## Requirements
- R1: Writing one to control bit 0 (OUT set) or bit 2 (IN set) at address 0 makes that direction's status one from the next cycle. The status reads back on control bit 5 (OUT) and bit 6 (IN), and is also driven on `out_nak_sts` / `in_nak_sts`.
- R2: Writing one to control bit 1 (OUT clear) or bit 3 (IN clear) at address 0 makes that direction's status zero from the next cycle. When the set and clear bits of one direction are both one in the same write, the status becomes zero.
- R3: While the OUT status is one, every OUT transaction (`txn_valid`=1, `txn_is_in`=0) gets handshake 01 (NAK) and `keep_data` stays 0.
- R4: While the IN status is one, every IN transaction gets handshake 01 (NAK). The OUT direction is not affected.
- R5: When the status of the transaction's direction is zero, the handshake is 10 (STALL) if `ep_stall` is set. Otherwise it is 01 (NAK) if `ep_nak` is set or `fifo_ready` is low. Otherwise it is 00 (ACK for OUT, send data for IN). `keep_data` is one exactly for a valid OUT transaction answered with 00.
- R6: A set request made while the direction's status is zero raises that direction's effective flag. The flag is one from the first clock edge on which the status is already one and that direction's busy input is low. With the bus idle, the flag appears one cycle after the status.
- R7: A set request made while that direction's effective flag is still one produces no later flag event, even after software clears the flag.
- R8: The flags are read at address 1, with OUT on bit 0 and IN on bit 1. Writing one to a bit clears that flag. Writing zero leaves it unchanged.
- R9: Control bit 4 (initialization complete) holds the value last written to it and reads back on bit 4. Reset clears it.
- R10: After reset both status bits and both flags are zero. Control bits 3..0 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 control, 1 flags |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| out_busy | input | 1 | An OUT transaction is in progress |
| in_busy | input | 1 | An IN transaction is in progress |
| txn_valid | input | 1 | A handshake decision is requested this cycle |
| txn_is_in | input | 1 | Transaction direction: 1 IN, 0 OUT |
| fifo_ready | input | 1 | FIFO has space (OUT) or data (IN) |
| ep_nak | input | 1 | Endpoint NAK bit |
| ep_stall | input | 1 | Endpoint STALL bit |
| hs_code | output | 2 | Handshake: 00 ACK/data, 01 NAK, 10 STALL |
| keep_data | output | 1 | Store the incoming OUT packet |
| out_nak_sts | output | 1 | OUT override status |
| in_nak_sts | output | 1 | IN override status |
| out_eff_flag | output | 1 | OUT override effective flag |
| in_eff_flag | output | 1 | IN override effective flag |

## Verification
The bench holds the busy input high across a set request. A design that raised the flag straight from the request would confirm the override while a transaction could still be acknowledged. It also writes set and clear in one word; a design that let set win would leave the override stuck on. It re-arms while the flag is pending and then clears the flag; a design that queued the second event would report a stray confirmation. It drives STALL together with NAK and an unready FIFO under both override states; a design with the wrong priority, or one that stores data under the override, shows a wrong handshake code or a stray `keep_data`.

// File: rtl/usb_gnak_pkg.sv
package usb_gnak_pkg;
    // Handshake codes returned for every transaction
    typedef enum logic [1:0] {
        HS_ACK   = 2'b00,
        HS_NAK   = 2'b01,
        HS_STALL = 2'b10
    } hs_e;

    localparam int N_DIR   = 2;
    localparam int DIR_OUT = 0;
    localparam int DIR_IN  = 1;

    // Control word bit positions (set/clear pairs are per direction: 2*d, 2*d+1)
    localparam int CTL_INIT_BIT = 2 * N_DIR;
    localparam int CTL_STS_BASE = CTL_INIT_BIT + 1;

    localparam logic ADDR_CTL  = 1'b0;
    localparam logic ADDR_FLAG = 1'b1;
endpackage

// File: rtl/gnak_dir.sv
// gnak_dir: override state for one transfer direction.
// Holds the status bit, an armed marker and the effective flag.
// Assumes set/clear/flag-clear are one-cycle pulses and busy is a level.
module gnak_dir (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    input  logic flag_clr,
    input  logic busy,
    output logic sts,
    output logic flag
);
    logic armed;
    logic raise;

    // Confirmation fires once status is on and no transaction is running
    assign raise = armed && sts && !busy;

    // Status, armed marker and flag update; clear beats set, raise beats W1C
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts   <= 1'b0;
            armed <= 1'b0;
            flag  <= 1'b0;
        end else begin
            if (clr_req)
                sts <= 1'b0;
            else if (set_req)
                sts <= 1'b1;

            if (clr_req || raise)
                armed <= 1'b0;
            else if (set_req && !sts && !flag && !armed)
                armed <= 1'b1;

            if (raise)
                flag <= 1'b1;
            else if (flag_clr)
                flag <= 1'b0;
        end
    end
endmodule

// File: rtl/gnak_hs_sel.sv
// gnak_hs_sel: combinational handshake selection for one transaction.
// Assumes the override status bits are registered elsewhere.
module gnak_hs_sel
    import usb_gnak_pkg::*;
(
    input  logic [N_DIR-1:0] gnak_sts,
    input  logic             txn_valid,
    input  logic             txn_is_in,
    input  logic             fifo_ready,
    input  logic             ep_nak,
    input  logic             ep_stall,
    output logic [1:0]       hs_code,
    output logic             keep_data
);
    hs_e hs;
    logic dir_gnak;

    assign dir_gnak = txn_is_in ? gnak_sts[DIR_IN] : gnak_sts[DIR_OUT];

    // Priority: global override, then STALL, then NAK/not ready, then ACK
    always_comb begin
        if (dir_gnak)
            hs = HS_NAK;
        else if (ep_stall)
            hs = HS_STALL;
        else if (ep_nak || !fifo_ready)
            hs = HS_NAK;
        else
            hs = HS_ACK;
    end

    assign hs_code   = hs;
    assign keep_data = txn_valid && !txn_is_in && (hs == HS_ACK);
endmodule

// File: rtl/gnak_regif.sv
// gnak_regif: decodes the two-word register window and builds read data.
// Assumes one write per cycle; read data is combinational from reg_addr.
module gnak_regif
    import usb_gnak_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic [N_DIR-1:0] sts,
    input  logic [N_DIR-1:0] flag,
    output logic [N_DIR-1:0] set_req,
    output logic [N_DIR-1:0] clr_req,
    output logic [N_DIR-1:0] flag_clr,
    output logic [REG_W-1:0] reg_rdata
);
    logic init_done;
    logic wr_ctl;
    logic wr_flag;
    logic unused_hi;

    assign wr_ctl    = reg_wr && (reg_addr == ADDR_CTL);
    assign wr_flag   = reg_wr && (reg_addr == ADDR_FLAG);
    assign unused_hi = ^reg_wdata;

    // Per-direction request decode
    for (genvar d = 0; d < N_DIR; d++) begin : g_dec
        assign set_req[d]  = wr_ctl  && reg_wdata[2*d];
        assign clr_req[d]  = wr_ctl  && reg_wdata[2*d+1];
        assign flag_clr[d] = wr_flag && reg_wdata[d];
    end

    // Initialization-complete bit, plain read/write
    always_ff @(posedge clk) begin
        if (!rst_n)
            init_done <= 1'b0;
        else if (wr_ctl)
            init_done <= reg_wdata[CTL_INIT_BIT];
    end

    // Read mux: request bits always read zero
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_CTL) begin
            reg_rdata[CTL_INIT_BIT] = init_done;
            reg_rdata[CTL_STS_BASE +: N_DIR] = sts;
        end else begin
            reg_rdata[N_DIR-1:0] = flag;
        end
    end
endmodule

// File: rtl/usb_gnak_ctrl.sv
// usb_gnak_ctrl: global IN/OUT NAK override and handshake selection.
// Assumes busy inputs are high for the whole of a running transaction.
module usb_gnak_ctrl
    import usb_gnak_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             out_busy,
    input  logic             in_busy,
    input  logic             txn_valid,
    input  logic             txn_is_in,
    input  logic             fifo_ready,
    input  logic             ep_nak,
    input  logic             ep_stall,
    output logic [1:0]       hs_code,
    output logic             keep_data,
    output logic             out_nak_sts,
    output logic             in_nak_sts,
    output logic             out_eff_flag,
    output logic             in_eff_flag
);
    logic [N_DIR-1:0] set_req, clr_req, flag_clr, busy, sts, flag;

    assign busy[DIR_OUT] = out_busy;
    assign busy[DIR_IN]  = in_busy;

    gnak_regif #(.REG_W(REG_W)) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .sts      (sts),
        .flag     (flag),
        .set_req  (set_req),
        .clr_req  (clr_req),
        .flag_clr (flag_clr),
        .reg_rdata(reg_rdata)
    );

    // One override state machine per direction
    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        gnak_dir u_dir (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_req (set_req[d]),
            .clr_req (clr_req[d]),
            .flag_clr(flag_clr[d]),
            .busy    (busy[d]),
            .sts     (sts[d]),
            .flag    (flag[d])
        );
    end

    gnak_hs_sel u_hs (
        .gnak_sts  (sts),
        .txn_valid (txn_valid),
        .txn_is_in (txn_is_in),
        .fifo_ready(fifo_ready),
        .ep_nak    (ep_nak),
        .ep_stall  (ep_stall),
        .hs_code   (hs_code),
        .keep_data (keep_data)
    );

    assign out_nak_sts  = sts[DIR_OUT];
    assign in_nak_sts   = sts[DIR_IN];
    assign out_eff_flag = flag[DIR_OUT];
    assign in_eff_flag  = flag[DIR_IN];
endmodule

// File: rtl/gnak_chk.sv
// gnak_chk: port-level properties of usb_gnak_ctrl, attached by bind.
module gnak_chk #(
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_addr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             out_busy,
    input logic             txn_valid,
    input logic             txn_is_in,
    input logic             ep_stall,
    input logic [1:0]       hs_code,
    input logic             keep_data,
    input logic             out_nak_sts,
    input logic             in_nak_sts,
    input logic             out_eff_flag
);
    AST_SET_OUT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_addr && reg_wdata[0] && !reg_wdata[1]) |=> out_nak_sts); // R1
    AST_CLEAR_WINS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_addr && reg_wdata[1]) |=> !out_nak_sts); // R2
    AST_OUT_GNAK_NAK: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_is_in && out_nak_sts) |-> (hs_code == 2'b01 && !keep_data)); // R3
    AST_IN_GNAK_NAK: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_is_in && in_nak_sts) |-> (hs_code == 2'b01)); // R4
    AST_STALL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && ep_stall && !(txn_is_in ? in_nak_sts : out_nak_sts)) |-> (hs_code == 2'b10)); // R5
    AST_KEEP_ONLY_OUT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        keep_data |-> (txn_valid && !txn_is_in && hs_code == 2'b00)); // R5
    AST_FLAG_AFTER_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_eff_flag) |-> ($past(out_nak_sts) && !$past(out_busy))); // R6
    AST_W1C_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_eff_flag && reg_wr && reg_addr && !reg_wdata[0]) |=> out_eff_flag); // R8
    AST_REQ_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_addr |-> (reg_rdata[3:0] == 4'b0000)); // R10
endmodule

bind usb_gnak_ctrl gnak_chk #(.REG_W(REG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .out_busy    (out_busy),
    .txn_valid   (txn_valid),
    .txn_is_in   (txn_is_in),
    .ep_stall    (ep_stall),
    .hs_code     (hs_code),
    .keep_data   (keep_data),
    .out_nak_sts (out_nak_sts),
    .in_nak_sts  (in_nak_sts),
    .out_eff_flag(out_eff_flag)
);

// File: tb/sim_usb_gnak_ctrl.sv
module sim_usb_gnak_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic out_busy = 1'b0, in_busy = 1'b0;
    logic txn_valid = 1'b0, txn_is_in = 1'b0, fifo_ready = 1'b1, ep_nak = 1'b0, ep_stall = 1'b0;
    logic [1:0] hs_code;
    logic keep_data, out_nak_sts, in_nak_sts, out_eff_flag, in_eff_flag;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    // Reference model state: index 0 OUT, 1 IN
    bit m_sts[2], m_flag[2], m_arm[2], m_init;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_gnak_ctrl u0 (.*);

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare all outputs against the model and current inputs
    task automatic compare(string req);
        int d, e_hs, e_rd;
        bit e_keep;
        d = txn_is_in ? 1 : 0;
        if (m_sts[d]) e_hs = 1;
        else if (ep_stall) e_hs = 2;
        else if (ep_nak || !fifo_ready) e_hs = 1;
        else e_hs = 0;
        e_keep = txn_valid && !txn_is_in && (e_hs == 0);
        if (!reg_addr) e_rd = (m_sts[1] << 6) | (m_sts[0] << 5) | (m_init << 4);
        else e_rd = (m_flag[1] << 1) | m_flag[0];
        chk(req, "out_nak_sts", out_nak_sts, m_sts[0]);
        chk(req, "in_nak_sts", in_nak_sts, m_sts[1]);
        chk(req, "out_eff_flag", out_eff_flag, m_flag[0]);
        chk(req, "in_eff_flag", in_eff_flag, m_flag[1]);
        chk(req, "reg_rdata", reg_rdata, e_rd);
        chk(req, "keep_data", keep_data, e_keep);
        if (txn_valid) chk(req, "hs_code", hs_code, e_hs);
    endtask

    // One clock: compare, then advance model with the inputs seen at the edge
    task automatic tick(string req);
        bit setr, clrr, fclr, busy, raise;
        #1 compare(req);
        @(posedge clk);
        if (!rst_n) begin
            for (int d = 0; d < 2; d++) begin m_sts[d] = 0; m_flag[d] = 0; m_arm[d] = 0; end
            m_init = 0;
        end else begin
            for (int d = 0; d < 2; d++) begin
                setr = reg_wr && !reg_addr && reg_wdata[2*d];
                clrr = reg_wr && !reg_addr && reg_wdata[2*d+1];
                fclr = reg_wr && reg_addr && reg_wdata[d];
                busy = (d == 0) ? out_busy : in_busy;
                raise = m_arm[d] && m_sts[d] && !busy;
                if (fclr) m_flag[d] = 0;
                if (raise) m_flag[d] = 1;
                if (clrr || raise) m_arm[d] = 0;
                else if (setr && !m_sts[d] && !m_flag[d] && !m_arm[d]) m_arm[d] = 1;
                if (clrr) m_sts[d] = 0;
                else if (setr) m_sts[d] = 1;
            end
            if (reg_wr && !reg_addr) m_init = reg_wdata[4];
        end
        @(negedge clk);
    endtask

    task automatic wr(bit a, logic [7:0] d, string req);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick(req);
        reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic idle(int n, string req);
        for (int i = 0; i < n; i++) tick(req);
    endtask

    task automatic txn(bit is_in, bit rdy, bit nak, bit stall, string req);
        txn_valid = 1; txn_is_in = is_in; fifo_ready = rdy; ep_nak = nak; ep_stall = stall;
        tick(req);
        txn_valid = 0;
    endtask

    task automatic all_txn(string req);
        for (int p = 0; p < 16; p++) txn(p[3], p[2], p[1], p[0], req);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        @(negedge clk);
        idle(3, "R10");
        rst_n = 1;
        idle(1, "R10");
        chk("R10", "rst out_nak_sts", out_nak_sts, 0);
        chk("R9", "rst init bit", reg_rdata[4], 0);

        // R5: full priority table with no override
        all_txn("R5");

        // R1/R6: OUT set, bus idle: status next cycle, flag one cycle later
        wr(0, 8'h01, "R1");
        chk("R1", "out status after set", out_nak_sts, 1);
        chk("R6", "flag not immediate", out_eff_flag, 0);
        idle(1, "R6");
        chk("R6", "flag after idle", out_eff_flag, 1);
        all_txn("R3");

        // R8: write zero keeps, write one clears
        wr(1, 8'h00, "R8");
        chk("R8", "W1C zero keeps", out_eff_flag, 1);
        wr(1, 8'h01, "R8");
        chk("R8", "W1C one clears", out_eff_flag, 0);

        // R6/R4: IN set while IN busy, flag held until busy drops
        in_busy = 1;
        wr(0, 8'h04, "R4");
        idle(4, "R6");
        chk("R6", "flag held while busy", in_eff_flag, 0);
        in_busy = 0;
        idle(1, "R6");
        chk("R6", "flag after busy drops", in_eff_flag, 1);
        all_txn("R4");
        wr(1, 8'h02, "R8");

        // R2: clear OUT, then set+clear together on IN and OUT
        wr(0, 8'h02, "R2");
        chk("R2", "out cleared", out_nak_sts, 0);
        wr(0, 8'h0F, "R2");
        chk("R2", "clear wins out", out_nak_sts, 0);
        chk("R2", "clear wins in", in_nak_sts, 0);
        idle(3, "R2");

        // R7: re-arm while flag pending gives no second event
        wr(0, 8'h01, "R7");
        idle(2, "R7");
        wr(0, 8'h02, "R7");
        wr(0, 8'h01, "R7");
        idle(2, "R7");
        wr(1, 8'h01, "R7");
        idle(5, "R7");
        chk("R7", "no second flag", out_eff_flag, 0);
        wr(0, 8'h02, "R7");

        // R9: init bit read/write
        wr(0, 8'h10, "R9");
        chk("R9", "init set", reg_rdata[4], 1);
        wr(0, 8'h00, "R9");
        chk("R9", "init cleared", reg_rdata[4], 0);

        // Mixed random traffic against the model
        for (int i = 0; i < 600; i++) begin
            reg_wr = ($urandom_range(0, 3) == 0);
            reg_addr = $urandom_range(0, 1);
            reg_wdata = 8'($urandom_range(0, 255));
            out_busy = $urandom_range(0, 1);
            in_busy = $urandom_range(0, 1);
            txn_valid = $urandom_range(0, 1);
            txn_is_in = $urandom_range(0, 1);
            fifo_ready = $urandom_range(0, 1);
            ep_nak = $urandom_range(0, 1);
            ep_stall = ($urandom_range(0, 3) == 0);
            tick("R5");
        end
        reg_wr = 0;
        idle(2, "R5");
        finished = 1;
        summary();
    end
endmodule